// File: doc/BRIEF.md
# Two-Buffer Read Prefetch Controller

This block sits in a bus target between the host-bus slave port and a memory-side fetch engine. Two data buffers sit between those two sides and take turns. The block sees a new read arrive and classifies it by its command code. It then watches whether the frame signal stays up to decide between a single-word read and a burst. During a burst it asks the fetch engine to fill the buffers in turn, in steps of one buffer length.

Each of the three prefetchable read commands has its own policy bit. An aggressive command asks for the other buffer as soon as one word has left the current one. A conservative command waits until the current buffer has been fully drained. Register accesses and configuration reads are always one word long, and a burst attempt at them is cut off after the first data handshake. When the frame signal drops during a burst, the block cancels any prefetch and forgets both buffers.

Top module: `rdpf_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fetch_req`, `disconnect` and `flush` are all 0.
- R2: The policy register is written with `pol_wr`/`pol_din`. Bit 0 controls memory read (command 4'h6), bit 1 controls read line (4'hE) and bit 2 controls read multiple (4'hC). A 1 selects aggressive prefetch.
- R3: After reset the policy register is 3'b100, so only read multiple is aggressive.
- R4: Under an aggressive policy, a word taken (`take`) from the current buffer requests a fetch into the other buffer one cycle later. This happens only if that buffer has not yet been requested.
- R5: Under a conservative policy, a fetch into the other buffer is requested only at the take that drains the 8th word of the current buffer.
- R6: `req_valid` is sampled at edge E0 and `frame` at the following edge E1. If `frame` is low at E1, one single-word fetch (`fetch_single`=1) of `req_addr` into buffer 0 follows. If `frame` is high and the command is prefetchable, a burst fetch (`fetch_single`=0) of `req_addr` into buffer 0 follows.
- R7: An aggressive early fetch is issued only when its start address is at most `mem_last` − 8. Otherwise that buffer is fetched at drain time, as under R5.
- R8: A request with `req_reg`=1, or with any command other than the three prefetchable ones (for example a configuration read, 4'hA), gets exactly one single-word fetch. If `frame` is still high, the first `take` produces a one-cycle `disconnect`.
- R9: If `frame` is low at any edge during a burst, `flush` pulses for one cycle. No further fetch is issued until a new request arrives.
- R10: Each burst fetch after the first targets the opposite buffer from the previous fetch. Its address is the previous fetch address plus 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pulse marking the address phase of a new read |
| req_cmd | input | 4 | Command code of the read |
| req_addr | input | AW | Start word address |
| req_reg | input | 1 | Access targets internal registers |
| frame | input | 1 | Frame active from the host bus |
| take | input | 1 | One word delivered to the host bus |
| mem_last | input | AW | Last valid memory word address |
| pol_wr | input | 1 | Write strobe for the policy register |
| pol_din | input | 3 | New policy bits |
| fetch_req | output | 1 | Fetch request pulse |
| fetch_addr | output | AW | Start address of the fetch |
| fetch_buf | output | 1 | Buffer that the fetch fills |
| fetch_single | output | 1 | Fetch is a single word |
| disconnect | output | 1 | Cut off a burst to a register or configuration space |
| flush | output | 1 | Cancel prefetches and mark both buffers empty |

## Verification
The bench targets the drain boundary, where the 8th take and a pending aggressive request meet. A design that counts wrong there would fetch one buffer twice, or fetch at the 7th word. It also runs the ceiling edge, where an aggressive early fetch must fall back to drain time; a design that got this wrong would prefetch past memory. It covers a burst attempted at register and configuration space, which should give one single fetch plus one disconnect and never a burst, and a frame drop mid-burst, after which any stray fetch is an error. Policy rewrites check that each command reads its own bit, so a swapped bit index shows up as early or late fetches.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_RD_LINE = 4'hE;
    localparam logic [3:0] CMD_RD_MULT = 4'hC;

    localparam logic [2:0] POLICY_RESET = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEC   = 2'd1,
        ST_BURST = 2'd2,
        ST_REGW  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic pf;
        logic agg;
    } cmd_class_t;

    function automatic cmd_class_t classify(input logic [3:0] cmd, input logic is_reg,
                                            input logic [2:0] pol);
        cmd_class_t c;
        c.pf  = 1'b0;
        c.agg = 1'b0;
        if (!is_reg) begin
            unique case (cmd)
                CMD_MEM_RD:  begin c.pf = 1'b1; c.agg = pol[0]; end
                CMD_RD_LINE: begin c.pf = 1'b1; c.agg = pol[1]; end
                CMD_RD_MULT: begin c.pf = 1'b1; c.agg = pol[2]; end
                default:     begin c.pf = 1'b0; c.agg = 1'b0; end
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/rdpf_policy.sv
module rdpf_policy
    import rdpf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic [2:0] din_i,
    output logic [2:0] pol_o
);
    always_ff @(posedge clk) begin
        if (rst)       pol_o <= POLICY_RESET;
        else if (wr_i) pol_o <= din_i;
    end

    // R3
    pol_reset_chk: assert property (@(posedge clk) $fell(rst) |-> pol_o == POLICY_RESET);
endmodule

// File: rtl/rdpf_classify.sv
module rdpf_classify
    import rdpf_pkg::*;
(
    input  logic [3:0] cmd_i,
    input  logic       reg_i,
    input  logic [2:0] pol_i,
    output cmd_class_t cls_o
);
    always_comb cls_o = classify(cmd_i, reg_i, pol_i);
endmodule

// File: rtl/rdpf_seq.sv
module rdpf_seq
    import rdpf_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BUF_WORDS = 8,
    parameter int CEIL_GAP  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid_i,
    input  logic [3:0]    req_cmd_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic          req_reg_i,
    input  logic          frame_i,
    input  logic          take_i,
    input  logic [AW-1:0] mem_last_i,
    input  cmd_class_t    cls_i,
    output logic [3:0]    cmd_q_o,
    output logic          reg_q_o,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic          fetch_buf_o,
    output logic          fetch_single_o,
    output logic          disc_o,
    output logic          flush_o
);
    localparam int CW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BUF_WORDS - 1);
    localparam logic [AW-1:0] STEP     = AW'(BUF_WORDS);

    seq_st_e       st_q;
    logic [AW-1:0] addr_q, nxt_q;
    logic [CW-1:0] cnt_q;
    logic          rdb_q, issued_q, agg_q;

    logic [AW-1:0] ceil;
    logic          drain, early_ok;
    always_comb begin
        ceil     = mem_last_i - AW'(CEIL_GAP);
        drain    = take_i && (cnt_q == LAST_IDX);
        early_ok = agg_q && !issued_q && (nxt_q <= ceil);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; addr_q <= '0; nxt_q <= '0; cnt_q <= '0;
            rdb_q <= 1'b0; issued_q <= 1'b0; agg_q <= 1'b0;
            cmd_q_o <= '0; reg_q_o <= 1'b0;
            fetch_req_o <= 1'b0; fetch_addr_o <= '0; fetch_buf_o <= 1'b0;
            fetch_single_o <= 1'b0; disc_o <= 1'b0; flush_o <= 1'b0;
        end else begin
            fetch_req_o <= 1'b0;
            disc_o      <= 1'b0;
            flush_o     <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid_i) begin
                    cmd_q_o <= req_cmd_i;
                    reg_q_o <= req_reg_i;
                    addr_q  <= req_addr_i;
                    st_q    <= ST_DEC;
                end
                ST_DEC: begin
                    fetch_req_o  <= 1'b1;
                    fetch_addr_o <= addr_q;
                    fetch_buf_o  <= 1'b0;
                    cnt_q <= '0; rdb_q <= 1'b0; issued_q <= 1'b0;
                    nxt_q <= addr_q + STEP;
                    agg_q <= cls_i.agg;
                    if (frame_i && cls_i.pf) begin
                        fetch_single_o <= 1'b0;
                        st_q <= ST_BURST;
                    end else begin
                        fetch_single_o <= 1'b1;
                        st_q <= (frame_i && !cls_i.pf) ? ST_REGW : ST_IDLE;
                    end
                end
                ST_BURST: begin
                    if (!frame_i) begin
                        flush_o  <= 1'b1;
                        issued_q <= 1'b0;
                        st_q     <= ST_IDLE;
                    end else if (drain) begin
                        cnt_q <= '0;
                        rdb_q <= !rdb_q;
                        issued_q <= 1'b0;
                        if (!issued_q) begin
                            fetch_req_o    <= 1'b1;
                            fetch_addr_o   <= nxt_q;
                            fetch_buf_o    <= !rdb_q;
                            fetch_single_o <= 1'b0;
                            nxt_q          <= nxt_q + STEP;
                        end
                    end else if (take_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (early_ok) begin
                            fetch_req_o    <= 1'b1;
                            fetch_addr_o   <= nxt_q;
                            fetch_buf_o    <= !rdb_q;
                            fetch_single_o <= 1'b0;
                            nxt_q          <= nxt_q + STEP;
                            issued_q       <= 1'b1;
                        end
                    end
                end
                ST_REGW: begin
                    if (!frame_i) st_q <= ST_IDLE;
                    else if (take_i) begin
                        disc_o <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: address of the previous fetch
    logic [AW-1:0] prev_addr_q;
    always_ff @(posedge clk) begin
        if (rst) prev_addr_q <= '0;
        else if (fetch_req_o) prev_addr_q <= fetch_addr_o;
    end

    // R8
    disc_from_regw_chk: assert property (@(posedge clk) disable iff (rst)
        disc_o |-> $past(st_q == ST_REGW));
    // R8
    np_single_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && $past(st_q == ST_DEC) && !$past(cls_i.pf)) |-> fetch_single_o);
    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !fetch_req_o);
    // R5
    cons_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !$past(st_q == ST_DEC) && !agg_q) |-> $past(cnt_q) == LAST_IDX);
    // R10
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && !$past(st_q == ST_DEC)) |-> fetch_addr_o == prev_addr_q + STEP);
    // R6
    first_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_o && $past(st_q == ST_DEC)) |-> !fetch_buf_o);
endmodule

// File: rtl/rdpf_ctrl.sv
module rdpf_ctrl
    import rdpf_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BUF_WORDS = 8,
    parameter int CEIL_GAP  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [3:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic          req_reg,
    input  logic          frame,
    input  logic          take,
    input  logic [AW-1:0] mem_last,
    input  logic          pol_wr,
    input  logic [2:0]    pol_din,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_buf,
    output logic          fetch_single,
    output logic          disconnect,
    output logic          flush
);
    logic [2:0]  pol;
    logic [3:0]  cmd_q;
    logic        reg_q;
    cmd_class_t  cls;

    rdpf_policy u_pol (
        .clk(clk), .rst(rst), .wr_i(pol_wr), .din_i(pol_din), .pol_o(pol)
    );

    rdpf_classify u_cls (
        .cmd_i(cmd_q), .reg_i(reg_q), .pol_i(pol), .cls_o(cls)
    );

    rdpf_seq #(.AW(AW), .BUF_WORDS(BUF_WORDS), .CEIL_GAP(CEIL_GAP)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_addr_i(req_addr),
        .req_reg_i(req_reg), .frame_i(frame), .take_i(take), .mem_last_i(mem_last),
        .cls_i(cls), .cmd_q_o(cmd_q), .reg_q_o(reg_q),
        .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_buf_o(fetch_buf),
        .fetch_single_o(fetch_single), .disc_o(disconnect), .flush_o(flush)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !fetch_req && !disconnect && !flush);
endmodule

// File: tb/rdpf_ctrl_tb_top.sv
module rdpf_ctrl_tb_top;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_reg = 0, frame = 0, take = 0, pol_wr = 0;
    logic [3:0] req_cmd = 0;
    logic [AW-1:0] req_addr = 0, mem_last = 16'h01FF;
    logic [2:0] pol_din = 0;
    logic fetch_req, fetch_buf, fetch_single, disconnect, flush;
    logic [AW-1:0] fetch_addr;

    always #4 clk = ~clk;

    rdpf_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_reg(req_reg), .frame(frame), .take(take),
        .mem_last(mem_last), .pol_wr(pol_wr), .pol_din(pol_din),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_buf(fetch_buf),
        .fetch_single(fetch_single), .disconnect(disconnect), .flush(flush)
    );

    int n_vec = 0, n_bad = 0, cyc = 0;
    string tag = "R1";
    bit done = 0;

    // Behavioural reference model
    int m_st = 0, m_cnt = 0, m_rdb = 0, m_iss = 0, m_agg = 0, m_pf = 0;
    int m_pol = 4, m_cmd = 0, m_reg = 0, m_addr = 0, m_nxt = 0;
    bit e_req = 0, e_buf = 0, e_single = 0, e_disc = 0, e_flush = 0;
    int e_addr = 0;

    function automatic int agg_of(int cmd, int pol);
        if (cmd == 6)  return (pol >> 0) & 1;
        if (cmd == 14) return (pol >> 1) & 1;
        return (pol >> 2) & 1;
    endfunction

    task automatic emit(int a, int b, bit s);
        e_req = 1; e_addr = a; e_buf = b[0]; e_single = s;
    endtask

    always @(posedge clk) begin
        e_req = 0; e_disc = 0; e_flush = 0;
        if (rst) begin
            m_st = 0; m_pol = 4;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_cmd = int'(req_cmd); m_reg = int'(req_reg); m_addr = int'(req_addr); m_st = 1;
                end
                1: begin
                    m_pf = (!m_reg && (m_cmd == 6 || m_cmd == 14 || m_cmd == 12)) ? 1 : 0;
                    m_agg = m_pf ? agg_of(m_cmd, m_pol) : 0;
                    m_cnt = 0; m_rdb = 0; m_iss = 0; m_nxt = (m_addr + 8) % 65536;
                    if (frame && m_pf) begin emit(m_addr, 0, 0); m_st = 2; end
                    else begin emit(m_addr, 0, 1); m_st = (frame && !m_pf) ? 3 : 0; end
                end
                2: begin
                    if (!frame) begin e_flush = 1; m_st = 0; end
                    else if (take && m_cnt == 7) begin
                        if (!m_iss) begin emit(m_nxt, 1 - m_rdb, 0); m_nxt = (m_nxt + 8) % 65536; end
                        m_cnt = 0; m_rdb = 1 - m_rdb; m_iss = 0;
                    end else if (take) begin
                        m_cnt++;
                        if (m_agg && !m_iss && m_nxt <= int'(mem_last) - 8) begin
                            emit(m_nxt, 1 - m_rdb, 0); m_nxt = (m_nxt + 8) % 65536; m_iss = 1;
                        end
                    end
                end
                3: begin
                    if (!frame) m_st = 0;
                    else if (take) begin e_disc = 1; m_st = 0; end
                end
                default: m_st = 0;
            endcase
            if (pol_wr) m_pol = int'(pol_din);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            n_vec++;
            if (fetch_req !== e_req || disconnect !== e_disc || flush !== e_flush ||
                (e_req && (int'(fetch_addr) != e_addr || fetch_buf !== e_buf ||
                           fetch_single !== e_single))) begin
                n_bad++;
                $display("FAIL %s cyc %0d: act req=%b addr=%h buf=%b sgl=%b disc=%b flush=%b exp req=%b addr=%h buf=%b sgl=%b disc=%b flush=%b",
                    tag, cyc, fetch_req, fetch_addr, fetch_buf, fetch_single, disconnect, flush,
                    e_req, e_addr[15:0], e_buf, e_single, e_disc, e_flush);
            end
        end
        if (cyc == 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start(logic [3:0] cmd, int addr, bit isreg, bit hold);
        @(negedge clk);
        req_valid = 1; req_cmd = cmd; req_addr = addr[AW-1:0]; req_reg = isreg; frame = 1;
        @(negedge clk);
        req_valid = 0; frame = hold;
        @(negedge clk);
        frame = hold;
    endtask

    task automatic takes(int n);
        for (int i = 0; i < n; i++) begin take = 1; @(negedge clk); end
        take = 0;
    endtask

    task automatic end_frame();
        frame = 0; idle(3);
    endtask

    initial begin
        tag = "R1"; idle(4); rst = 0; idle(3);
        // R3: read multiple aggressive by default; R4 early fetch; R10 chain
        tag = "R4"; start(4'hC, 'h100, 0, 1); takes(1); idle(2); takes(7);
        tag = "R10"; takes(3); idle(1); takes(13);
        tag = "R9"; end_frame();
        // R3: memory read conservative by default; R5 drain fetch
        tag = "R5"; start(4'h6, 'h040, 0, 1); takes(4); idle(2); takes(4); takes(9);
        tag = "R9"; end_frame(); takes(2);
        // R2: rewrite policy so memory read is aggressive, read multiple conservative
        tag = "R2"; @(negedge clk); pol_wr = 1; pol_din = 3'b001; @(negedge clk); pol_wr = 0;
        start(4'h6, 'h200, 0, 1); takes(10); end_frame();
        start(4'hC, 'h300, 0, 1); takes(10); end_frame();
        start(4'hE, 'h500, 0, 1); takes(9); end_frame();
        @(negedge clk); pol_wr = 1; pol_din = 3'b010; @(negedge clk); pol_wr = 0;
        start(4'hE, 'h600, 0, 1); takes(2); end_frame();
        // R6: one-cycle frame gives a single-word fetch
        tag = "R6"; start(4'hC, 'h0A0, 0, 0); takes(2); idle(2);
        // R7: ceiling blocks aggressive early fetch
        tag = "R7"; @(negedge clk); pol_wr = 1; pol_din = 3'b111; mem_last = 16'h010F;
        @(negedge clk); pol_wr = 0;
        start(4'hC, 'h100, 0, 1); takes(3); takes(5); takes(3); end_frame();
        mem_last = 16'h0110; start(4'hC, 'h100, 0, 1); takes(2); end_frame();
        mem_last = 16'h01FF;
        // R8: configuration burst, register burst, register single
        tag = "R8"; start(4'hA, 'h010, 0, 1); idle(2); takes(3); end_frame();
        start(4'h6, 'h020, 1, 1); takes(2); end_frame();
        start(4'hC, 'h030, 1, 0); takes(1); idle(2);
        start(4'hA, 'h040, 0, 1); frame = 0; takes(2); idle(2);
        // R9: frame drop immediately after burst start
        tag = "R9"; start(4'hC, 'h700, 0, 1); end_frame(); takes(4);
        // R1: reset mid-burst
        tag = "R1"; start(4'hC, 'h800, 0, 1); takes(2); rst = 1; idle(2); rst = 0; frame = 0; idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule